// File: doc/BRIEF.md
# Phase-Adaptive Reconstitution Period Tuner

The tuner picks, at run time, how long a banished cache block must wait before it may be allowed back into the private caches. It watches the memory system in fixed-length epochs. In each epoch it sums the latency of completed memory operations and counts those operations, the L1 accesses and the L1 hits. While tracking, it compares each epoch's average latency with the previous epoch's. A shift of more than 5% is taken as a new program phase.

On a new phase the tuner sweeps a fixed set of five candidate periods. Each candidate runs for one epoch and is scored by its L1 hit rate. The best candidate is then driven on `period_o` and held until the next phase change. No divider is used: averages and rates are compared by cross-multiplying. The consumer is the per-block reconstitution down-counter, which reads `period_o` as its decrement interval.

Top module: `period_tuner`

## Requirements
- R1: An epoch lasts `EPOCH_LEN` clock cycles (default 10000). An epoch's totals take effect on `period_o` and `explore_o` at the second rising edge counted from the edge that samples the epoch's last cycle.
- R2: While reset is asserted and after its release, `period_o` is 500 and `explore_o` is 0.
- R3: In tracking mode a phase change is declared when 20·|S_cur·N_ref − S_ref·N_cur| > S_ref·N_cur. Here S is a latency sum and N an operation count, so the average must move by strictly more than 5% of the reference average, upward or downward. A shift of exactly 5% is not a phase change.
- R4: The test compares averages rather than sums, so an epoch with fewer operations but the same mean latency is not a phase change. If either epoch saw zero completed operations, no phase change is declared.
- R5: On a phase change `explore_o` goes to 1. The period then steps through 10, 50, 100, 500 and 1000 in that order, one epoch each, with `period_o` showing the candidate under trial.
- R6: A candidate is scored by hits/accesses over its epoch, compared by cross-multiplication. A later candidate replaces the best only when its rate is strictly higher, so on a tie the earlier candidate is kept.
- R7: After the 1000 epoch, `explore_o` returns to 0 and `period_o` takes the winning candidate. It holds that value through any number of epochs without a phase change.
- R8: Latency changes during exploration epochs do not restart or alter the sweep.
- R9: The first tracking epoch after reset, and the first after an exploration, only records a new reference and never declares a phase change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_done_i | input | 1 | Pulse: a memory operation completed this cycle |
| op_lat_i | input | LAT_W | Latency of the operation completing this cycle |
| l1_acc_i | input | 1 | Pulse: an L1 access this cycle |
| l1_hit_i | input | 1 | Pulse: that access hit; counted only with `l1_acc_i` |
| period_o | output | 10 | Reconstitution period currently selected, in cycles |
| explore_o | output | 1 | High while candidate periods are being swept |

## Verification
The hardest situations to reach from the ports are those in which a wrong reference would be used. Examples are a tracking epoch that directly follows an exploration, and an epoch that follows one with no completed operations. The stimulus reaches them by moving the latency sharply in the epoch right after a sweep and by inserting an idle epoch. A correct tuner stays quiet in both cases. The hit stream is generated from the `period_o` value the bench observes, as a closed loop. Per-candidate hit rates are chosen to give a clear maximum, a three-way tie and a winner in the last slot, so the chosen period is known in advance.

// File: rtl/tuner_pkg.sv
package tuner_pkg;
  localparam int NUM_CAND  = 5;
  localparam int CIDX_W    = 3;
  localparam int PER_W     = 10;
  localparam int RATE_MUL  = 20;  // 1/0.05
  localparam int RESET_IDX = 3;   // 500 cycles

  typedef enum logic {MODE_TRACK, MODE_EXPLORE} mode_e;

  function automatic logic [PER_W-1:0] cand_period(input logic [CIDX_W-1:0] idx);
    case (idx)
      3'd0:    cand_period = PER_W'(10);
      3'd1:    cand_period = PER_W'(50);
      3'd2:    cand_period = PER_W'(100);
      3'd3:    cand_period = PER_W'(500);
      default: cand_period = PER_W'(1000);
    endcase
  endfunction
endpackage

// File: rtl/epoch_accum.sv
module epoch_accum #(
  parameter int unsigned EPOCH_LEN = 10000,
  parameter int unsigned LAT_W     = 8,
  parameter int unsigned CNT_W     = 14,
  parameter int unsigned SUM_W     = 22
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             op_done_i,
  input  logic [LAT_W-1:0] op_lat_i,
  input  logic             l1_acc_i,
  input  logic             l1_hit_i,
  output logic             snap_vld_o,
  output logic [SUM_W-1:0] snap_sum_o,
  output logic [CNT_W-1:0] snap_ops_o,
  output logic [CNT_W-1:0] snap_acc_o,
  output logic [CNT_W-1:0] snap_hit_o
);
  logic [CNT_W-1:0] ep_cnt_q, ops_q, acc_q, hit_q;
  logic [SUM_W-1:0] sum_q;
  logic [CNT_W-1:0] ops_n, acc_n, hit_n;
  logic [SUM_W-1:0] sum_n;
  logic             ep_last;

  assign ep_last = (ep_cnt_q == CNT_W'(EPOCH_LEN - 1));

  always_comb begin
    sum_n = sum_q + (op_done_i ? SUM_W'(op_lat_i) : '0);
    ops_n = ops_q + CNT_W'(op_done_i);
    acc_n = acc_q + CNT_W'(l1_acc_i);
    hit_n = hit_q + CNT_W'(l1_acc_i & l1_hit_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ep_cnt_q   <= '0;
      sum_q      <= '0;
      ops_q      <= '0;
      acc_q      <= '0;
      hit_q      <= '0;
      snap_vld_o <= 1'b0;
      snap_sum_o <= '0;
      snap_ops_o <= '0;
      snap_acc_o <= '0;
      snap_hit_o <= '0;
    end else begin
      snap_vld_o <= ep_last;
      if (ep_last) begin
        ep_cnt_q   <= '0;
        snap_sum_o <= sum_n;
        snap_ops_o <= ops_n;
        snap_acc_o <= acc_n;
        snap_hit_o <= hit_n;
        sum_q      <= '0;
        ops_q      <= '0;
        acc_q      <= '0;
        hit_q      <= '0;
      end else begin
        ep_cnt_q <= ep_cnt_q + CNT_W'(1);
        sum_q    <= sum_n;
        ops_q    <= ops_n;
        acc_q    <= acc_n;
        hit_q    <= hit_n;
      end
    end
  end

  a_r1_cnt_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ep_cnt_q < CNT_W'(EPOCH_LEN));
  a_r1_snap_follows_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ep_last |=> snap_vld_o);
  a_r1_snap_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snap_vld_o |=> !snap_vld_o || (EPOCH_LEN == 1));
  a_r6_hits_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snap_vld_o |-> (snap_hit_o <= snap_acc_o));
endmodule

// File: rtl/phase_detect.sv
module phase_detect #(
  parameter int unsigned CNT_W = 14,
  parameter int unsigned SUM_W = 22
) (
  input  logic [SUM_W-1:0] cur_sum_i,
  input  logic [CNT_W-1:0] cur_ops_i,
  input  logic [SUM_W-1:0] ref_sum_i,
  input  logic [CNT_W-1:0] ref_ops_i,
  output logic             change_o
);
  import tuner_pkg::*;
  localparam int unsigned PROD_W = SUM_W + CNT_W;
  localparam int unsigned SCL_W  = PROD_W + 5;

  logic [PROD_W-1:0] cur_norm, ref_norm, diff;
  logic [SCL_W-1:0]  diff_scaled;

  always_comb begin
    cur_norm    = PROD_W'(cur_sum_i) * PROD_W'(ref_ops_i);
    ref_norm    = PROD_W'(ref_sum_i) * PROD_W'(cur_ops_i);
    diff        = (cur_norm > ref_norm) ? (cur_norm - ref_norm) : (ref_norm - cur_norm);
    diff_scaled = SCL_W'(diff) * SCL_W'(RATE_MUL);
    change_o    = (cur_ops_i != '0) && (ref_ops_i != '0) && (diff_scaled > SCL_W'(ref_norm));
  end
endmodule

// File: rtl/explore_ctrl.sv
module explore_ctrl #(
  parameter int unsigned CNT_W = 14,
  parameter int unsigned SUM_W = 22
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        snap_vld_i,
  input  logic [SUM_W-1:0]            snap_sum_i,
  input  logic [CNT_W-1:0]            snap_ops_i,
  input  logic [CNT_W-1:0]            snap_acc_i,
  input  logic [CNT_W-1:0]            snap_hit_i,
  input  logic                        change_i,
  output logic [SUM_W-1:0]            ref_sum_o,
  output logic [CNT_W-1:0]            ref_ops_o,
  output logic [tuner_pkg::PER_W-1:0] period_o,
  output logic                        explore_o
);
  import tuner_pkg::*;
  localparam int unsigned MUL_W = 2 * CNT_W;
  localparam logic [CIDX_W-1:0] LAST_IDX = CIDX_W'(NUM_CAND - 1);

  mode_e             mode_q;
  logic              ref_vld_q;
  logic [CIDX_W-1:0] idx_q, best_idx_q;
  logic [CNT_W-1:0]  best_hit_q, best_acc_q;
  logic [PER_W-1:0]  period_q;
  logic              better;
  logic [CIDX_W-1:0] win_idx;

  // strict compare keeps the earlier candidate on a tie
  always_comb begin
    if (idx_q == '0)
      better = 1'b1;
    else if (best_acc_q == '0)
      better = (snap_hit_i != '0);
    else
      better = (MUL_W'(snap_hit_i) * MUL_W'(best_acc_q)) >
               (MUL_W'(best_hit_q) * MUL_W'(snap_acc_i));
    win_idx = better ? idx_q : best_idx_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q     <= MODE_TRACK;
      ref_vld_q  <= 1'b0;
      ref_sum_o  <= '0;
      ref_ops_o  <= '0;
      idx_q      <= '0;
      best_idx_q <= '0;
      best_hit_q <= '0;
      best_acc_q <= '0;
      period_q   <= cand_period(CIDX_W'(RESET_IDX));
    end else if (snap_vld_i) begin
      if (mode_q == MODE_TRACK) begin
        ref_sum_o <= snap_sum_i;
        ref_ops_o <= snap_ops_i;
        ref_vld_q <= 1'b1;
        if (ref_vld_q && change_i) begin
          mode_q   <= MODE_EXPLORE;
          idx_q    <= '0;
          period_q <= cand_period('0);
        end
      end else begin
        if (better) begin
          best_idx_q <= idx_q;
          best_hit_q <= snap_hit_i;
          best_acc_q <= snap_acc_i;
        end
        if (idx_q == LAST_IDX) begin
          mode_q    <= MODE_TRACK;
          ref_vld_q <= 1'b0;
          period_q  <= cand_period(win_idx);
        end else begin
          idx_q    <= idx_q + CIDX_W'(1);
          period_q <= cand_period(idx_q + CIDX_W'(1));
        end
      end
    end
  end

  assign period_o  = period_q;
  assign explore_o = (mode_q == MODE_EXPLORE);

  a_r7_hold_between_epochs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !snap_vld_i |=> $stable(period_o) && $stable(explore_o));
  a_r5_enter_sweep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (snap_vld_i && !explore_o && ref_vld_q && change_i) |=>
      (explore_o && period_o == PER_W'(10)));
  a_r8_sweep_advances: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (snap_vld_i && explore_o && idx_q != LAST_IDX) |=>
      (explore_o && idx_q == $past(idx_q) + CIDX_W'(1)));
  a_r7_sweep_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (snap_vld_i && explore_o && idx_q == LAST_IDX) |=> !explore_o);
  a_r9_reference_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (snap_vld_i && !explore_o && !ref_vld_q) |=> !explore_o);
  a_r4_idle_epoch_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (snap_vld_i && !explore_o && snap_ops_i == '0) |=> !explore_o);
endmodule

// File: rtl/period_tuner.sv
module period_tuner #(
  parameter int unsigned EPOCH_LEN = 10000,
  parameter int unsigned LAT_W     = 8
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        op_done_i,
  input  logic [LAT_W-1:0]            op_lat_i,
  input  logic                        l1_acc_i,
  input  logic                        l1_hit_i,
  output logic [tuner_pkg::PER_W-1:0] period_o,
  output logic                        explore_o
);
  localparam int unsigned CNT_W = $clog2(EPOCH_LEN + 1);
  localparam int unsigned SUM_W = CNT_W + LAT_W;

  logic             snap_vld;
  logic [SUM_W-1:0] snap_sum, ref_sum;
  logic [CNT_W-1:0] snap_ops, snap_acc, snap_hit, ref_ops;
  logic             change;

  epoch_accum #(.EPOCH_LEN(EPOCH_LEN), .LAT_W(LAT_W), .CNT_W(CNT_W), .SUM_W(SUM_W)) u_accum (
    .clk_i, .rst_ni, .op_done_i, .op_lat_i, .l1_acc_i, .l1_hit_i,
    .snap_vld_o(snap_vld), .snap_sum_o(snap_sum), .snap_ops_o(snap_ops),
    .snap_acc_o(snap_acc), .snap_hit_o(snap_hit)
  );

  phase_detect #(.CNT_W(CNT_W), .SUM_W(SUM_W)) u_detect (
    .cur_sum_i(snap_sum), .cur_ops_i(snap_ops),
    .ref_sum_i(ref_sum), .ref_ops_i(ref_ops), .change_o(change)
  );

  explore_ctrl #(.CNT_W(CNT_W), .SUM_W(SUM_W)) u_ctrl (
    .clk_i, .rst_ni, .snap_vld_i(snap_vld), .snap_sum_i(snap_sum),
    .snap_ops_i(snap_ops), .snap_acc_i(snap_acc), .snap_hit_i(snap_hit),
    .change_i(change), .ref_sum_o(ref_sum), .ref_ops_o(ref_ops),
    .period_o, .explore_o
  );
endmodule

// File: tb/period_tuner_tb_top.sv
`timescale 1ns/1ps
module period_tuner_tb_top;
  localparam int EP  = 100;
  localparam int LW  = 10;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          op_done_i = 1'b0;
  logic [LW-1:0] op_lat_i = '0;
  logic          l1_acc_i = 1'b0;
  logic          l1_hit_i = 1'b0;
  logic [9:0]    period_o;
  logic          explore_o;

  int n_chk = 0;
  int n_err = 0;
  int k_tab [5];
  bit done = 1'b0;

  always #2 clk = ~clk;

  period_tuner #(.EPOCH_LEN(EP), .LAT_W(LW)) dut_i (
    .clk_i(clk), .rst_ni, .op_done_i, .op_lat_i, .l1_acc_i, .l1_hit_i,
    .period_o, .explore_o
  );

  function automatic int k_of(input logic [9:0] p);
    case (p)
      10'd10:   return k_tab[0];
      10'd50:   return k_tab[1];
      10'd100:  return k_tab[2];
      10'd500:  return k_tab[3];
      10'd1000: return k_tab[4];
      default:  return 0;
    endcase
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // mode: 0 idle, 1 op every cycle, 2 op every other cycle
  task automatic drive_epoch(input int lat, input int mode, input bit do_chk,
                             input int exp_per, input int exp_expl, input string req,
                             input bit edge_chk = 1'b0, input int pre_per = 0);
    for (int c = 0; c < EP; c++) begin
      op_lat_i  = LW'(lat);
      op_done_i = (mode == 1) || (mode == 2 && (c % 2) == 0);
      l1_acc_i  = 1'b1;
      l1_hit_i  = (c % 10) < k_of(period_o);
      if (edge_chk && c == 0) chk({req, " before update"}, int'(period_o), pre_per);
      if (edge_chk && c == 1) chk({req, " after update"}, int'(period_o), exp_per);
      if (do_chk && c == 50) begin
        chk({req, " period"}, int'(period_o), exp_per);
        chk({req, " explore"}, int'(explore_o), exp_expl);
      end
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    chk("R2 reset period", int'(period_o), 500);
    chk("R2 reset explore", int'(explore_o), 0);
    rst_ni = 1'b1;
  endtask

  task automatic t_track_threshold;
    k_tab = '{3, 5, 9, 6, 4};
    drive_epoch(100, 1, 1, 500, 0, "R2 after release");
    drive_epoch(100, 1, 1, 500, 0, "R9 reference epoch");
    drive_epoch(105, 1, 1, 500, 0, "R3 steady");
    drive_epoch(105, 1, 1, 500, 0, "R3 exactly five percent");
    drive_epoch(112, 1, 1, 500, 0, "R3 steady again");
  endtask

  task automatic t_explore_max;
    drive_epoch(112, 1, 1, 10,  1, "R1 R5 cand 10", 1'b1, 500);
    drive_epoch(112, 1, 1, 50,  1, "R5 cand 50");
    drive_epoch(112, 1, 1, 100, 1, "R5 cand 100");
    drive_epoch(112, 1, 1, 500, 1, "R5 cand 500");
    drive_epoch(112, 1, 1, 1000,1, "R5 cand 1000");
    drive_epoch(150, 1, 1, 100, 0, "R6 R7 max wins", 1'b1, 1000);
  endtask

  task automatic t_normalise;
    drive_epoch(150, 2, 1, 100, 0, "R9 first epoch after sweep");
    drive_epoch(150, 0, 1, 100, 0, "R4 half op count same mean");
    drive_epoch(150, 1, 1, 100, 0, "R4 idle epoch");
    drive_epoch(300, 1, 1, 100, 0, "R4 after idle reference");
  endtask

  task automatic t_tie_suppress;
    k_tab = '{2, 8, 8, 8, 2};
    drive_epoch(300, 1, 1, 10,  1, "R3 downward-ready R5 cand 10");
    drive_epoch(600, 1, 1, 50,  1, "R8 latency jump in sweep");
    drive_epoch(600, 1, 1, 100, 1, "R8 sweep continues");
    drive_epoch(600, 1, 1, 500, 1, "R8 sweep continues");
    drive_epoch(600, 1, 1, 1000,1, "R8 sweep continues");
    drive_epoch(600, 1, 1, 50,  0, "R6 tie keeps earlier");
    drive_epoch(600, 1, 1, 50,  0, "R7 hold");
    drive_epoch(400, 1, 1, 50,  0, "R7 hold");
  endtask

  task automatic t_last_wins;
    k_tab = '{2, 3, 4, 5, 9};
    drive_epoch(400, 1, 1, 10,  1, "R3 downward shift R5 cand 10");
    drive_epoch(400, 1, 1, 50,  1, "R5 cand 50");
    drive_epoch(400, 1, 1, 100, 1, "R5 cand 100");
    drive_epoch(400, 1, 1, 500, 1, "R5 cand 500");
    drive_epoch(400, 1, 1, 1000,1, "R5 cand 1000");
    drive_epoch(400, 1, 1, 1000,0, "R6 last candidate wins");
    drive_epoch(400, 1, 1, 1000,0, "R7 hold after sweep");
  endtask

  task automatic finish_run;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_track_threshold();
    t_explore_max();
    t_normalise();
    t_tie_suppress();
    t_last_wins();
    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog R1 actual=timeout expected=completion");
      finish_run();
    end
  end
endmodule